// File: doc/BRIEF.md
# MMIO Byte-Order Steering Stage

This stage sits on the data path of a PCI-side bus interface unit. It takes one access per cycle from a 32-bit target port or from the internal processor. Each access is tagged with its source and its class: register space (MMIO), plain memory traffic, or the unit's own special registers. The stage forwards the access to an internal bus on which byte 0 always sits in lane 0. It decides per access whether the byte lanes of the data and of the byte enables are mirrored. Read data that returns from the internal side goes back through the same steering.

The stage holds a one-bit swap-enable flag in a control register at a parameterised word address. When the flag is clear, the host is taken to be big-endian, and host MMIO traffic is mirrored. This includes the host's own write to the control register, so a host that wants to set the flag must pre-mirror the value it writes. When the flag is set, host MMIO traffic passes straight through. Internal processor accesses, memory traffic and special-register traffic are never mirrored.

Each accepted access reaches the outputs one cycle later. The internal side answers reads combinationally in that cycle. The flag value used for an access is the one held when the access is accepted.

Top module: `mswap_stage`

## Requirements
- R1: The swap-enable flag is 0 after reset, so the first host MMIO access after reset is mirrored.
- R2: With the flag at 0, a host (src=1) MMIO (class 2'b00) access moves byte lane i to lane 3-i. This applies to both the forwarded write data and the returned read data.
- R3: With the flag at 1, host MMIO write data and read data pass through unchanged.
- R4: Internal processor (src=0) MMIO accesses are never mirrored, whatever the flag value.
- R5: Memory traffic (class 2'b01) is never mirrored, from either source, in either flag state.
- R6: Special-register traffic (class 2'b10, and the spare code 2'b11) is never mirrored.
- R7: The control register sits at word address CTRL_ADDR, and the flag is bit 0 of that word. A write to it is steered like any other MMIO write. The flag takes bit 0 of the steered data only if steered byte-enable bit 0 is set. With the flag at 0, a host must therefore place the new value in bit 24 with byte-enable bit 3.
- R8: A flag change applies from the next accepted access onward. The write that changes the flag is itself steered with the old value.
- R9: Byte enables are mirrored together with their data lanes whenever the data is mirrored.
- R10: A read of the control register returns a word that holds the flag in bit 0 and zeros elsewhere. That word is steered like any other MMIO read.
- R11: The outputs for an accepted access appear in the following cycle. int_valid is low in idle cycles and for control-register accesses. host_rvalid is high exactly in the cycle after an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access offered and accepted this cycle |
| req_src | input | 1 | 0 internal processor, 1 PCI host |
| req_class | input | 2 | 00 MMIO, 01 memory, 10/11 special register |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data as presented by the source |
| req_be | input | DATA_W/8 | Byte enables as presented by the source |
| int_valid | output | 1 | Access forwarded to the internal bus |
| int_write | output | 1 | Forwarded direction |
| int_class | output | 2 | Forwarded class |
| int_addr | output | ADDR_W | Forwarded address |
| int_wdata | output | DATA_W | Steered write data |
| int_be | output | DATA_W/8 | Steered byte enables |
| int_rdata | input | DATA_W | Read data from the internal side, same cycle as int_valid |
| host_rdata | output | DATA_W | Steered read data returned to the source |
| host_rvalid | output | 1 | host_rdata is valid |

## Verification
A flag that is wrong inside the stage shows up at the ports on the very next host MMIO access. The data and the byte enables come out mirrored when they should not be, or the reverse. It also shows up on any read of the control register. A flag updated from the unsteered word instead of the steered word can be seen right after a single host write to the control register. So can a flag that takes effect one access early: the write itself, or the access issued back-to-back after it, is steered the wrong way in the next cycle. A steering decision that leaks across sources or classes shows up on the first processor, memory or special-register access that carries distinct byte values.

// File: rtl/mswap_pkg.sv
package mswap_pkg;

    typedef enum logic {
        SRC_CPU  = 1'b0,
        SRC_HOST = 1'b1
    } src_e;

    typedef enum logic [1:0] {
        CLS_MMIO = 2'b00,
        CLS_MEM  = 2'b01,
        CLS_SPEC = 2'b10,
        CLS_RSVD = 2'b11
    } cls_e;

endpackage

// File: rtl/mswap_lane_rev.sv
// Mirrors the order of LANES lanes of LANE_W bits when en is high.
module mswap_lane_rev #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                      en,
    input  logic [LANES*LANE_W-1:0]   din,
    output logic [LANES*LANE_W-1:0]   dout
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[i*LANE_W +: LANE_W] = en ? din[(LANES-1-i)*LANE_W +: LANE_W]
                                             : din[i*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/mswap_decode.sv
// Decides per access whether lanes are mirrored and whether the control word is hit.
module mswap_decode
    import mswap_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0100
) (
    input  logic              src,
    input  logic [1:0]        cls,
    input  logic [ADDR_W-1:0] addr,
    input  logic              se,
    output logic              swap,
    output logic              ctrl_hit
);
    logic is_mmio;
    logic is_host;

    always_comb begin
        is_mmio  = (cls_e'(cls) == CLS_MMIO);
        is_host  = (src_e'(src) == SRC_HOST);
        swap     = is_mmio && is_host && !se;
        ctrl_hit = is_mmio && (addr[ADDR_W-1:2] == CTRL_ADDR[ADDR_W-1:2]);
    end
endmodule

// File: rtl/mswap_se_update.sv
// Next value of the swap-enable flag from a steered control-register write.
module mswap_se_update #(
    parameter int DATA_W = 32,
    parameter int SE_BIT = 0
) (
    input  logic                  se_q,
    input  logic                  wr_hit,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [DATA_W/8-1:0]   be,
    output logic                  se_d
);
    localparam int SE_LANE = SE_BIT / 8;

    always_comb begin
        se_d = se_q;
        if (wr_hit && be[SE_LANE]) begin
            se_d = wdata[SE_BIT];
        end
    end
endmodule

// File: rtl/mswap_stage.sv
module mswap_stage
    import mswap_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0100,
    parameter int                SE_BIT    = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_src,
    input  logic [1:0]            req_class,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_be,
    output logic                  int_valid,
    output logic                  int_write,
    output logic [1:0]            int_class,
    output logic [ADDR_W-1:0]     int_addr,
    output logic [DATA_W-1:0]     int_wdata,
    output logic [DATA_W/8-1:0]   int_be,
    input  logic [DATA_W-1:0]     int_rdata,
    output logic [DATA_W-1:0]     host_rdata,
    output logic                  host_rvalid
);
    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        logic              vld;
        logic              write;
        logic [1:0]        cls;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  be;
        logic              swap;
        logic              hit;
        logic              ctrl_rd;
        logic              se;
    } stage_t;

    stage_t st_d, st_q;
    logic   se_q;

    logic              swap_now;
    logic              hit_now;
    logic [DATA_W-1:0] wd_steer;
    logic [LANES-1:0]  be_steer;
    logic              se_next;
    logic [DATA_W-1:0] rd_pre;

    assign se_q = st_q.se;

    mswap_decode #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_decode (
        .src      (req_src),
        .cls      (req_class),
        .addr     (req_addr),
        .se       (se_q),
        .swap     (swap_now),
        .ctrl_hit (hit_now)
    );

    mswap_lane_rev #(.LANES(LANES), .LANE_W(8)) u_wd_rev (
        .en   (swap_now),
        .din  (req_wdata),
        .dout (wd_steer)
    );

    mswap_lane_rev #(.LANES(LANES), .LANE_W(1)) u_be_rev (
        .en   (swap_now),
        .din  (req_be),
        .dout (be_steer)
    );

    mswap_se_update #(.DATA_W(DATA_W), .SE_BIT(SE_BIT)) u_se (
        .se_q   (se_q),
        .wr_hit (req_valid && hit_now && req_write),
        .wdata  (wd_steer),
        .be     (be_steer),
        .se_d   (se_next)
    );

    always_comb begin
        st_d         = st_q;
        st_d.vld     = req_valid;
        st_d.se      = se_next;
        if (req_valid) begin
            st_d.write   = req_write;
            st_d.cls     = req_class;
            st_d.addr    = req_addr;
            st_d.wdata   = wd_steer;
            st_d.be      = be_steer;
            st_d.swap    = swap_now;
            st_d.hit     = hit_now;
            st_d.ctrl_rd = se_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_pre = int_rdata;
        if (st_q.hit) begin
            rd_pre = DATA_W'(st_q.ctrl_rd) << SE_BIT;
        end
    end

    mswap_lane_rev #(.LANES(LANES), .LANE_W(8)) u_rd_rev (
        .en   (st_q.swap),
        .din  (rd_pre),
        .dout (host_rdata)
    );

    assign int_valid   = st_q.vld && !st_q.hit;
    assign int_write   = st_q.write;
    assign int_class   = st_q.cls;
    assign int_addr    = st_q.addr;
    assign int_wdata   = st_q.wdata;
    assign int_be      = st_q.be;
    assign host_rvalid = st_q.vld && !st_q.write;

endmodule

// File: rtl/mswap_stage_chk.sv
module mswap_stage_chk #(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0100
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_src,
    input logic [1:0]          req_class,
    input logic                req_write,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [DATA_W-1:0]   req_wdata,
    input logic [DATA_W/8-1:0] req_be,
    input logic                int_valid,
    input logic [DATA_W-1:0]   int_wdata,
    input logic [DATA_W/8-1:0] int_be,
    input logic                host_rvalid,
    input logic                se_q
);
    localparam int LANES = DATA_W / 8;

    function automatic logic [DATA_W-1:0] mirror_d(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*8 +: 8] = v[(LANES-1-i)*8 +: 8];
        return r;
    endfunction

    function automatic logic [LANES-1:0] mirror_b(input logic [LANES-1:0] v);
        logic [LANES-1:0] r;
        for (int i = 0; i < LANES; i++) r[i] = v[LANES-1-i];
        return r;
    endfunction

    p_se_reset_r1: assert property (@(posedge clk) !rst_n |=> !se_q);

    p_host_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src && req_class == 2'b00 && !se_q)
        |=> int_wdata == mirror_d($past(req_wdata)));

    p_host_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src && req_class == 2'b00 && se_q)
        |=> int_wdata == $past(req_wdata));

    p_cpu_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_src) |=> int_wdata == $past(req_wdata) && int_be == $past(req_be));

    p_mem_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == 2'b01) |=> int_wdata == $past(req_wdata));

    p_spec_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class[1]) |=> int_wdata == $past(req_wdata));

    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && req_class == 2'b00
          && req_addr[ADDR_W-1:2] == CTRL_ADDR[ADDR_W-1:2]) |=> $stable(se_q));

    p_be_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src && req_class == 2'b00 && !se_q)
        |=> int_be == mirror_b($past(req_be)));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !int_valid && !host_rvalid);

    p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> host_rvalid);

endmodule

bind mswap_stage mswap_stage_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_src     (req_src),
    .req_class   (req_class),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_be      (req_be),
    .int_valid   (int_valid),
    .int_wdata   (int_wdata),
    .int_be      (int_be),
    .host_rvalid (host_rvalid),
    .se_q        (se_q)
);

// File: tb/mswap_stage_test.sv
module mswap_stage_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] CTRL = 16'h0100;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, req_src = 0, req_write = 0;
    logic [1:0]  req_class = 0;
    logic [15:0] req_addr = 0;
    logic [31:0] req_wdata = 0;
    logic [3:0]  req_be = 0;
    logic        int_valid, int_write, host_rvalid;
    logic [1:0]  int_class;
    logic [15:0] int_addr;
    logic [31:0] int_wdata, int_rdata, host_rdata;
    logic [3:0]  int_be;

    int checks = 0, fails = 0;
    logic m_se = 0;
    logic seen = 0;

    typedef struct {
        string       tag;
        logic [31:0] wd;
        logic [3:0]  be;
        logic        ivld;
        logic        rvld;
        logic [31:0] rd;
    } item_t;
    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mem_img(input logic [15:0] a);
        return {a[7:0] ^ 8'h5A, 8'hC3, a[15:8], 8'h17};
    endfunction
    function automatic logic [31:0] rev32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction
    function automatic logic [3:0] rev4(input logic [3:0] v);
        return {v[0], v[1], v[2], v[3]};
    endfunction

    assign int_rdata = mem_img(int_addr);

    mswap_stage uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_class(req_class), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .int_valid(int_valid),
        .int_write(int_write), .int_class(int_class), .int_addr(int_addr),
        .int_wdata(int_wdata), .int_be(int_be), .int_rdata(int_rdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: computes the expected result from the requirements and issues the access.
    task automatic put(input string tag, input logic src, input logic [1:0] cls,
                       input logic wr, input logic [15:0] addr,
                       input logic [31:0] d, input logic [3:0] be);
        item_t it;
        logic sw, hit;
        logic [31:0] pre;
        sw  = src && cls == 2'b00 && !m_se;
        hit = cls == 2'b00 && addr[15:2] == CTRL[15:2];
        it.tag  = tag;
        it.wd   = sw ? rev32(d) : d;
        it.be   = sw ? rev4(be) : be;
        it.ivld = !hit;
        it.rvld = !wr;
        pre     = hit ? {31'b0, m_se} : mem_img(addr);
        it.rd   = sw ? rev32(pre) : pre;
        if (hit && wr && it.be[0]) m_se = it.wd[0];
        exp_q.push_back(it);
        req_valid = 1; req_src = src; req_class = cls; req_write = wr;
        req_addr = addr; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic idle(input int n);
        req_valid = 0;
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) seen <= req_valid && rst_n;

    // Monitor: compares the outputs of each accepted access one cycle later.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (seen) begin
                if (exp_q.size() == 0) begin
                    check("R11 unexpected output", 32'd1, 32'd0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check({it.tag, " int_valid"}, {31'b0, int_valid}, {31'b0, it.ivld});
                    check({it.tag, " host_rvalid"}, {31'b0, host_rvalid}, {31'b0, it.rvld});
                    check({it.tag, " wdata"}, int_wdata, it.wd);
                    check({it.tag, " be"}, {28'b0, int_be}, {28'b0, it.be});
                    if (it.rvld) check({it.tag, " rdata"}, host_rdata, it.rd);
                end
            end else begin
                check("R11 idle", {30'b0, int_valid, host_rvalid}, 32'd0);
            end
        end
    end

    task automatic finish_up;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R11 reset int_valid", {31'b0, int_valid}, 32'd0);
        check("R11 reset host_rvalid", {31'b0, host_rvalid}, 32'd0);
        // R1 R2 R9: flag clear after reset, host MMIO mirrored
        put("R1 R2 R9 host wr", 1, 2'b00, 1, 16'h0040, 32'h11223344, 4'b0011);
        put("R2 host rd", 1, 2'b00, 0, 16'h0044, 32'h0, 4'b1111);
        idle(1);
        // R4 processor MMIO untouched
        put("R4 cpu wr", 0, 2'b00, 1, 16'h0048, 32'hA1B2C3D4, 4'b0001);
        put("R4 cpu rd", 0, 2'b00, 0, 16'h004C, 32'h0, 4'b1111);
        // R5 memory traffic untouched
        put("R5 host mem wr", 1, 2'b01, 1, 16'h2000, 32'h01020304, 4'b0111);
        put("R5 host mem rd", 1, 2'b01, 0, 16'h2004, 32'h0, 4'b1111);
        // R6 special registers untouched
        put("R6 spec wr", 1, 2'b10, 1, 16'h0100, 32'hDEADBEEF, 4'b1000);
        put("R6 spare rd", 1, 2'b11, 0, 16'h0300, 32'h0, 4'b1111);
        // R7 unmirrored value lands in bit 24: flag stays clear
        put("R7 ctrl naive wr", 1, 2'b00, 1, CTRL, 32'h00000001, 4'b0001);
        put("R10 ctrl rd clear", 1, 2'b00, 0, CTRL, 32'h0, 4'b1111);
        put("R7 still mirrored", 1, 2'b00, 1, 16'h0050, 32'h55667788, 4'b1100);
        // R7 R8 pre-mirrored write sets flag; next access back-to-back passes
        put("R7 R8 ctrl set", 1, 2'b00, 1, CTRL, 32'h01000000, 4'b1000);
        put("R8 R3 host wr", 1, 2'b00, 1, 16'h0054, 32'h99AABBCC, 4'b0010);
        put("R3 host rd", 1, 2'b00, 0, 16'h0058, 32'h0, 4'b1111);
        put("R10 ctrl rd set", 1, 2'b00, 0, CTRL, 32'h0, 4'b1111);
        put("R4 cpu wr se1", 0, 2'b00, 1, 16'h005C, 32'h0F1E2D3C, 4'b0100);
        put("R5 cpu mem wr", 0, 2'b01, 1, 16'h3000, 32'h12345678, 4'b1111);
        idle(2);
        // R4 R7 processor clears the flag without mirroring
        put("R4 R7 cpu ctrl clr", 0, 2'b00, 1, CTRL, 32'h00000000, 4'b0001);
        put("R8 R2 host wr again", 1, 2'b00, 1, 16'h0060, 32'hCAFEF00D, 4'b1110);
        put("R10 cpu ctrl rd", 0, 2'b00, 0, CTRL, 32'h0, 4'b1111);
        idle(3);
        check("R11 queue drained", exp_q.size(), 32'd0);
        finish_up();
    end
endmodule